// File: doc/BRIEF.md
# Bus Grant Arbiter for a Request/Grant/Acknowledge Handshake

This block sits on the side of the processor that owns the bus by default. Other masters ask for the bus on one active-high request line. When several masters share it, that line is their wired OR. The arbiter decides when to offer the bus and drives a grant line.

An external master takes ownership by raising acknowledge. The arbiter then withdraws the grant after a fixed delay. If requests are still pending, it offers the bus again shortly afterwards, even while the current master keeps acknowledge high. This lets outside circuitry choose the next master before the current one finishes.

The local transfer engine reports whether a transfer is in progress. A grant from local ownership waits for that transfer to end. A halted processor, or one stopped on a double bus fault, has no transfer running, so requests are served at once in those states. Request and acknowledge are used directly in synchronous mode. Otherwise they pass through a two-flop synchronizer first.

All pins are plain control and status levels; nothing carries a data stream, so there is no valid/ready interface.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While the processor owns the bus, grant_o is asserted only after req_i has been sampled high with ack_i sampled low. A request with acknowledge held high gets no grant until acknowledge falls.
- R2: With sync_mode_i=1 and the bus idle (xfer_idle_i=1), grant_o is high immediately after the first clock edge that samples req_i high.
- R3: With sync_mode_i=0, request and acknowledge each pass through two flops. Every response to them lands two edges later than in synchronous mode, so a grant from an idle bus appears after the third edge.
- R4: grant_o goes low on the second edge after the edge at which a rising ack_i is first seen, plus two edges in asynchronous mode.
- R5: After grant_o falls, if the request is still high, grant_o rises again on the second edge after the fall, whatever ack_i is doing.
- R6: halt_i=1 or dfault_i=1 counts as "no transfer running": a request is granted even while xfer_idle_i=0.
- R7: A request that arrives during a local transfer gets no grant until xfer_idle_i is high. grant_o then rises on the first edge that samples xfer_idle_i high.
- R8: If the request falls while an offer is pending and acknowledge is low, the offer is withdrawn: grant_o goes low on the next edge that sees the low request.
- R9: local_owner_o rises on the first edge that sees request and acknowledge both low while grant_o is low or the offer is unanswered. While an external master holds acknowledge, local_owner_o stays low, and grant_o is never high together with local_owner_o.
- R10: Synchronous reset (rst=1) leaves grant_o=0 and local_owner_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode_i | input | 1 | 1 = request/acknowledge used directly, 0 = two-flop synchronized |
| req_i | input | 1 | Bus request, wired OR of external masters |
| ack_i | input | 1 | Bus grant acknowledge from the master that owns the bus |
| xfer_idle_i | input | 1 | Local transfer engine has no transfer in progress |
| halt_i | input | 1 | Processor halted |
| dfault_i | input | 1 | Processor stopped on a double bus fault |
| grant_o | output | 1 | Bus grant |
| local_owner_o | output | 1 | Processor owns the bus |

## Verification
The hardest state to reach is the speculative re-offer. An external master must already own the bus and keep acknowledge high while the wired request stays high. Only then does the arbiter drop the grant and raise it again. The bench reaches this by holding request through the whole acknowledge phase.

It then releases request and acknowledge together while the new offer is pending, and checks that the bus returns to the processor. Dropping request in the same cycle that acknowledge rises takes the other path, where the master keeps the bus with no new offer. Both paths are swept across both timing modes and several transfer-busy lengths. Expected latencies come from the edge counts in the requirements.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_LOCAL = 2'd0,
    ST_OFFER = 2'd1,
    ST_HOLD  = 2'd2,
    ST_GAP   = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
          stg_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
#(
  parameter int NEG_DLY     = 2,
  parameter int REOFFER_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic ack_i,
  input  logic ready_i,
  output logic grant_o,
  output logic local_o
);
  localparam int MAXD = (NEG_DLY > REOFFER_DLY) ? NEG_DLY : REOFFER_DLY;
  localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD + 1);
  localparam logic [CW-1:0] NEG_LOAD = CW'(NEG_DLY - 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(REOFFER_DLY - 1);

  arb_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          grant_q, ack_prev_q;
  logic          ack_rise;

  assign ack_rise = ack_i & ~ack_prev_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_LOCAL: begin
        if (req_i && !ack_i && ready_i) state_d = ST_OFFER;
      end
      ST_OFFER: begin
        if (ack_rise) begin
          state_d = ST_HOLD;
          cnt_d   = NEG_LOAD;
        end else if (!req_i) begin
          if (ack_i) begin
            state_d = ST_GAP;
            cnt_d   = GAP_LOAD;
          end else begin
            state_d = ST_LOCAL;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          state_d = ST_GAP;
          cnt_d   = GAP_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (!req_i && !ack_i)  state_d = ST_LOCAL;
        else if (cnt_q != '0)  cnt_d   = cnt_q - 1'b1;
        else if (req_i)        state_d = ST_OFFER;
      end
      default: state_d = ST_LOCAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_LOCAL;
      cnt_q      <= '0;
      grant_q    <= 1'b0;
      ack_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      grant_q    <= (state_d == ST_OFFER) || (state_d == ST_HOLD);
      ack_prev_q <= ack_i;
    end
  end

  assign grant_o = grant_q;
  assign local_o = (state_q == ST_LOCAL);

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_q) |-> $past(req_i)); // R1
  AST_LOCAL_NEEDS_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(grant_q) && $past(state_q == ST_LOCAL)) |-> !$past(ack_i)); // R1
  AST_IDLE_GRANT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCAL && req_i && !ack_i && ready_i) |=> grant_q); // R2
  AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCAL && !ready_i) |=> !grant_q); // R7
  AST_HOLD_KEEPS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> grant_q); // R4
  AST_GAP_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |-> !grant_q); // R5
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int NEG_DLY     = 2,
  parameter int REOFFER_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_mode_i,
  input  logic req_i,
  input  logic ack_i,
  input  logic xfer_idle_i,
  input  logic halt_i,
  input  logic dfault_i,
  output logic grant_o,
  output logic local_owner_o
);
  logic [1:0] raw_pair, sync_pair;
  logic       req_eff, ack_eff, ready;

  assign raw_pair = {ack_i, req_i};

  arb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_pair),
    .q_o (sync_pair)
  );

  assign req_eff = sync_mode_i ? req_i : sync_pair[0];
  assign ack_eff = sync_mode_i ? ack_i : sync_pair[1];
  assign ready   = xfer_idle_i | halt_i | dfault_i;

  arb_grant_fsm #(.NEG_DLY(NEG_DLY), .REOFFER_DLY(REOFFER_DLY)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_eff),
    .ack_i   (ack_eff),
    .ready_i (ready),
    .grant_o (grant_o),
    .local_o (local_owner_o)
  );

  AST_OWNER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    local_owner_o |-> !grant_o); // R9
  AST_REGAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(local_owner_o) |-> (!$past(req_eff) && !$past(ack_eff))); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (local_owner_o && !grant_o)); // R10
endmodule

// File: tb/bus_grant_arbiter_tb.sv
module bus_grant_arbiter_tb;
  logic clk = 1'b0;
  logic rst, sync_mode, req, ack, xidle, halt, dfault;
  logic grant, owner;
  int   n_tests = 0;
  int   n_fail  = 0;
  int   cyc     = 0;

  always #2 clk = ~clk;

  bus_grant_arbiter u_dut (
    .clk(clk), .rst(rst), .sync_mode_i(sync_mode), .req_i(req), .ack_i(ack),
    .xfer_idle_i(xidle), .halt_i(halt), .dfault_i(dfault),
    .grant_o(grant), .local_owner_o(owner)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected < 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req_tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic wait_grant(input logic val, output int n);
    n = 99;
    for (int t = 1; t <= 30; t++) begin
      tick();
      if (grant == val) begin n = t; break; end
    end
  endtask

  task automatic wait_owner(output int n);
    n = 99;
    for (int t = 1; t <= 30; t++) begin
      tick();
      if (owner) begin n = t; break; end
    end
  endtask

  task automatic do_reset(input logic mode);
    sync_mode = mode; req = 0; ack = 0; xidle = 1; halt = 0; dfault = 0;
    rst = 1;
    tick(2);
    rst = 0;
  endtask

  initial begin
    int n, lat, expg;
    // R10 reset state
    do_reset(1'b1);
    check("R10 grant", grant, 0);
    check("R10 owner", owner, 1);

    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 3; b++) begin
        for (int f = 0; f < 2; f++) begin
          do_reset(m == 0);
          lat  = (m == 0) ? 0 : 2;
          expg = ((1 + lat) > (b + 1)) ? (1 + lat) : (b + 1);
          // R2 R3 R7 grant latency from request
          xidle = (b == 0);
          req = 1;
          n = 99;
          for (int t = 1; t <= 30; t++) begin
            tick();
            if (grant) begin n = t; break; end
            if (t == b) xidle = 1;
          end
          check((b > 0) ? "R7 busy grant" : (m == 0 ? "R2 sync grant" : "R3 async grant"), n, expg);
          check("R9 owner low while granted", owner, 0);
          // R4 withdraw after acknowledge
          ack = 1;
          if (f == 0) req = 0;
          wait_grant(1'b0, n);
          check("R4 negate after ack", n, 3 + lat);
          if (f == 1) begin
            // R5 re-offer while ack held
            wait_grant(1'b1, n);
            check("R5 re-offer", n, 2);
            req = 0; ack = 0;
            wait_owner(n);
            check("R9 regain after re-offer", n, 1 + lat);
            check("R9 grant low on regain", grant, 0);
          end else begin
            tick(6);
            check("R9 master keeps bus", owner, 0);
            check("R5 no re-offer without req", grant, 0);
            ack = 0;
            wait_owner(n);
            check("R9 regain after release", n, 1 + lat);
          end
        end
      end
    end

    // R6 halt and double fault bypass busy transfer; R8 withdraw
    for (int k = 0; k < 2; k++) begin
      do_reset(1'b1);
      xidle = 0; halt = (k == 0); dfault = (k == 1);
      req = 1;
      wait_grant(1'b1, n);
      check(k == 0 ? "R6 halt grant" : "R6 dfault grant", n, 1);
      req = 0;
      wait_grant(1'b0, n);
      check("R8 withdraw", n, 1);
      check("R8 owner back", owner, 1);
    end

    // R1 acknowledge held blocks grant from local ownership
    do_reset(1'b1);
    ack = 1; req = 1;
    tick(6);
    check("R1 no grant with ack", grant, 0);
    check("R1 owner kept", owner, 1);
    ack = 0;
    wait_grant(1'b1, n);
    check("R1 grant after ack low", n, 1);
    req = 0;
    tick(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule